// File: doc/BRIEF.md
# Timed Strobe Slave Port

This block sits between a synchronous memory-mapped bus and a simple peripheral that needs slow, shaped control signals. When the bus presents a read or write request, the block raises a chip-select toward the peripheral. It drops the matching active-low read or write strobe after a configurable number of setup cycles, and keeps that strobe low for a configurable number of extra wait cycles. For writes it then keeps the peripheral-side address, byte enables and data stable for a configurable number of hold cycles. For the whole access, the bus master is stalled by a wait-request output.

The address, active-low byte enables and write data are captured in the first cycle of an access. The captured copies drive the peripheral until the access ends, so the peripheral sees stable values whatever the bus does meanwhile. Read data from the peripheral is returned to the bus in the final cycle of a read, which is also the cycle in which wait-request falls. When the setup, wait and hold counts are all zero, an access takes a single cycle and wait-request never rises.

Top module: `strobe_slave_port`

## Requirements
- R1: After reset, and in any cycle with no read or write request and no access in progress, chip-select is low, both strobes are high, wait-request is low and bus read data is all zeros.
- R2: A read lasts SETUP_CYC + WAIT_CYC + 1 cycles counted from the cycle the request first appears. Wait-request is high in every cycle but the last and low in the last.
- R3: Chip-select is high in every cycle of an access. The strobe belonging to the operation is low exactly in access cycles SETUP_CYC through SETUP_CYC + WAIT_CYC, counting the first cycle as 0.
- R4: A write lasts SETUP_CYC + WAIT_CYC + HOLD_CYC + 1 cycles. In the HOLD_CYC cycles after the write strobe rises, chip-select stays high and the peripheral address, byte enables and write data do not change.
- R5: With all three cycle counts at zero, every request completes in the cycle it appears: wait-request stays low and the strobe is low in that same cycle.
- R6: The peripheral address, byte enables and write data equal the bus values of the first access cycle for the whole access, even if the bus inputs change later in it.
- R7: If read and write requests are both high, a read is performed and the write strobe stays high.
- R8: Bus read data carries the peripheral read data only in the final cycle of a read. In every other cycle, including the final cycle of a write, it is all zeros.
- R9: The two strobes are never low together, and neither is low while chip-select is low.
- R10: A request that is present in the cycle right after an access completes starts a new access in that cycle, with no idle cycle in between.
- R11: Byte enables are active low (bit i low enables byte lane i, bits DATA_W/8-1..0) and reach the peripheral bit for bit, with no inversion or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus word address |
| bus_be_n | input | DATA_W/8 | Bus byte enables, active low |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Read data, valid in the final read cycle, zero otherwise |
| bus_waitreq | output | 1 | Stall toward the master, low in the final access cycle |
| per_cs | output | 1 | Peripheral chip-select, active high |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| per_addr | output | ADDR_W | Captured address toward the peripheral |
| per_be_n | output | DATA_W/8 | Captured byte enables, active low |
| per_wdata | output | DATA_W | Captured write data |
| per_rdata | input | DATA_W | Read data from the peripheral |

## Verification
The bench checks the strobe window cycle by cycle against the access index. An off-by-one in the setup or wait counter would shift the strobe or make wait-request fall one cycle early or late. Hold cycles are checked separately for writes and reads: a design that applied them to reads would stall reads too long, and one that dropped them would release writes as the strobe rises. Bus inputs are scrambled in the middle of an access, which exposes a design that drives the peripheral from the live bus instead of the captured copy. The bench also covers simultaneous read and write requests, back-to-back accesses with no idle cycle, and a second instance with all counts at zero. Together these catch a write winning the conflict, a lost cycle between accesses, and a zero-count configuration that still stalls for one cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } ssp_op_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } ssp_seq_e;

    // Per-cycle control word produced by the sequencer.
    typedef struct packed {
        logic    active;   // an access occupies this cycle
        logic    first;    // first cycle of the access (capture cycle)
        logic    strobe;   // strobe window is open
        logic    last;     // final cycle of the access
        ssp_op_e op;       // operation of the access
    } ssp_ctl_t;

    // Read outranks write when both are requested.
    function automatic ssp_op_e pick_op(input logic rd, input logic wr);
        if (rd)
            return OP_READ;
        else if (wr)
            return OP_WRITE;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/ssp_sequencer.sv
module ssp_sequencer
    import ssp_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned WAIT_CYC  = 3,
    parameter int unsigned HOLD_CYC  = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_rd,
    input  logic     req_wr,
    output ssp_ctl_t ctl_o
);
    localparam int unsigned STROBE_END = SETUP_CYC + WAIT_CYC;
    localparam int unsigned RD_LAST    = STROBE_END;
    localparam int unsigned WR_LAST    = STROBE_END + HOLD_CYC;
    localparam int unsigned CW         = $clog2(WR_LAST + 2);

    ssp_seq_e        state_q;
    logic [CW-1:0]   cnt_q;
    ssp_op_e         op_q;

    ssp_op_e         live_op;
    ssp_op_e         cur_op;
    logic [CW-1:0]   idx;
    logic [CW-1:0]   last_idx;
    int unsigned     pos;
    logic            active;

    always_comb begin
        live_op = pick_op(req_rd, req_wr);
        if (state_q == SEQ_IDLE) begin
            idx    = '0;
            cur_op = live_op;
            active = (live_op != OP_NONE);
        end else begin
            idx    = cnt_q;
            cur_op = op_q;
            active = 1'b1;
        end
        last_idx = (cur_op == OP_WRITE) ? CW'(WR_LAST) : CW'(RD_LAST);
        // pos is the 1-based cycle number inside the access
        pos = 32'(idx) + 32'd1;

        ctl_o.active = active;
        ctl_o.first  = active && (state_q == SEQ_IDLE);
        ctl_o.strobe = active && (pos > SETUP_CYC) && (pos <= STROBE_END + 1);
        ctl_o.last   = active && (idx == last_idx);
        ctl_o.op     = cur_op;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_NONE;
        end else if (active) begin
            if (idx == last_idx) begin
                state_q <= SEQ_IDLE;
                cnt_q   <= '0;
                op_q    <= OP_NONE;
            end else begin
                state_q <= SEQ_BUSY;
                cnt_q   <= idx + CW'(1);
                op_q    <= cur_op;
            end
        end
    end

    // R2: a running access always knows its operation
    p_busy_has_op_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_BUSY) |-> (op_q != OP_NONE));

    // R4: the counter never runs past the longest access
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_BUSY) |-> (cnt_q <= CW'(WR_LAST)));

endmodule

// File: rtl/ssp_capture.sv
module ssp_capture #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              first_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BE_W-1:0]   be_n_o,
    output logic [DATA_W-1:0] wdata_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_n_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            be_n_q  <= '1;
            wdata_q <= '0;
        end else if (first_i) begin
            addr_q  <= addr_i;
            be_n_q  <= be_n_i;
            wdata_q <= wdata_i;
        end
    end

    // Cycle 0 shows the live bus so a zero-count access fits in one cycle.
    always_comb begin
        if (first_i) begin
            addr_o  = addr_i;
            be_n_o  = be_n_i;
            wdata_o = wdata_i;
        end else begin
            addr_o  = addr_q;
            be_n_o  = be_n_q;
            wdata_o = wdata_q;
        end
    end

    // R6: after the first cycle the peripheral side does not move
    p_capture_stable_r6: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> ($stable(addr_o) && $stable(be_n_o) && $stable(wdata_o)));

endmodule

// File: rtl/ssp_strobe_gen.sv
module ssp_strobe_gen
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              active_i,
    input  logic              strobe_i,
    input  logic              last_i,
    input  ssp_op_e           op_i,
    input  logic [DATA_W-1:0] per_rdata_i,
    output logic              cs_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              waitreq_o,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        cs_o      = active_i;
        rd_n_o    = !(strobe_i && (op_i == OP_READ));
        wr_n_o    = !(strobe_i && (op_i == OP_WRITE));
        waitreq_o = active_i && !last_i;
        rdata_o   = (last_i && (op_i == OP_READ)) ? per_rdata_i : '0;
    end

    // R9: immediate guards on the strobe pair
    always_comb begin
        a_strobe_excl_r9: assert (rd_n_o || wr_n_o);
        a_strobe_in_cs_r9: assert ((rd_n_o && wr_n_o) || cs_o);
    end

endmodule

// File: rtl/strobe_slave_port.sv
module strobe_slave_port
    import ssp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned WAIT_CYC  = 3,
    parameter int unsigned HOLD_CYC  = 2,
    localparam int unsigned BE_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_waitreq,
    output logic              per_cs,
    output logic              per_rd_n,
    output logic              per_wr_n,
    output logic [ADDR_W-1:0] per_addr,
    output logic [BE_W-1:0]   per_be_n,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata
);
    ssp_ctl_t ctl;

    ssp_sequencer #(
        .SETUP_CYC (SETUP_CYC),
        .WAIT_CYC  (WAIT_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) seq_i (
        .clk    (clk),
        .rst    (rst),
        .req_rd (bus_rd),
        .req_wr (bus_wr),
        .ctl_o  (ctl)
    );

    ssp_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) cap_i (
        .clk     (clk),
        .rst     (rst),
        .first_i (ctl.first),
        .busy_i  (ctl.active && !ctl.first),
        .addr_i  (bus_addr),
        .be_n_i  (bus_be_n),
        .wdata_i (bus_wdata),
        .addr_o  (per_addr),
        .be_n_o  (per_be_n),
        .wdata_o (per_wdata)
    );

    ssp_strobe_gen #(
        .DATA_W (DATA_W)
    ) stb_i (
        .active_i    (ctl.active),
        .strobe_i    (ctl.strobe),
        .last_i      (ctl.last),
        .op_i        (ctl.op),
        .per_rdata_i (per_rdata),
        .cs_o        (per_cs),
        .rd_n_o      (per_rd_n),
        .wr_n_o      (per_wr_n),
        .waitreq_o   (bus_waitreq),
        .rdata_o     (bus_rdata)
    );

    // R9: strobes exclusive and only under chip-select
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!per_rd_n && !per_wr_n));
    p_strobe_in_cs_r9: assert property (@(posedge clk) disable iff (rst)
        (!per_rd_n || !per_wr_n) |-> per_cs);

    // R2: a read is released only while its strobe is low
    p_read_done_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && per_cs && !bus_waitreq) |-> !per_rd_n);

    // R7: a conflicting write request never drives the write strobe
    p_read_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |-> per_wr_n);

    // R4: in a hold cycle the peripheral side is unchanged
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(per_wr_n) && $past(bus_waitreq)) |->
            (per_cs && $stable(per_addr) && $stable(per_be_n) && $stable(per_wdata)));

    // R1: with no request and no access the port is quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !bus_wr && !per_cs) |-> (!bus_waitreq && per_rd_n && per_wr_n));

    // R8: read data is zero when no read finishes
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_waitreq || !bus_rd) |-> (bus_rdata == '0));

endmodule

// File: tb/strobe_slave_port_tb_top.sv
module strobe_slave_port_tb_top;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int S  = 2;
    localparam int W  = 3;
    localparam int H  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [BW-1:0] bus_be_n = '1;
    logic [DW-1:0] bus_wdata = '0;

    logic [DW-1:0] bus_rdata, per_rdata, per_wdata;
    logic          bus_waitreq, per_cs, per_rd_n, per_wr_n;
    logic [AW-1:0] per_addr;
    logic [BW-1:0] per_be_n;

    logic [DW-1:0] z_rdata, z_per_rdata, z_per_wdata;
    logic          z_waitreq, z_cs, z_rd_n, z_wr_n;
    logic [AW-1:0] z_per_addr;
    logic [BW-1:0] z_per_be_n;

    function automatic logic [DW-1:0] pmodel(input logic [AW-1:0] a);
        return (DW'(a) * 32'h0001_9E37) ^ 32'hA5A5_0F0F;
    endfunction

    assign per_rdata   = pmodel(per_addr);
    assign z_per_rdata = pmodel(z_per_addr);

    strobe_slave_port #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .WAIT_CYC(W), .HOLD_CYC(H)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq),
        .per_cs(per_cs), .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .per_addr(per_addr),
        .per_be_n(per_be_n), .per_wdata(per_wdata), .per_rdata(per_rdata));

    strobe_slave_port #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(0), .WAIT_CYC(0), .HOLD_CYC(0)) dut_z_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(z_rdata), .bus_waitreq(z_waitreq),
        .per_cs(z_cs), .per_rd_n(z_rd_n), .per_wr_n(z_wr_n), .per_addr(z_per_addr),
        .per_be_n(z_per_be_n), .per_wdata(z_per_wdata), .per_rdata(z_per_rdata));

    typedef struct {
        bit            is_rd;
        bit            is_wr;
        int            len;
        logic [AW-1:0] addr;
        logic [BW-1:0] be_n;
        logic [DW-1:0] wdata;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc_k = 0;
    bit   finished = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: pushes the expected item, holds the request until release.
    task automatic access(input bit rd, input bit wr, input logic [AW-1:0] a, input logic [BW-1:0] be,
                          input logic [DW-1:0] d, input bit scramble, input int gap);
        exp_t e;
        int   n;
        e.is_rd = rd;
        e.is_wr = wr && !rd;
        e.len   = S + W + 1 + (e.is_wr ? H : 0);
        e.addr  = a;
        e.be_n  = be;
        e.wdata = d;
        sb_q.push_back(e);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_be_n = be; bus_wdata = d;
        n = 0;
        forever begin
            @(negedge clk); #1;
            if (!bus_waitreq || n > 40) break;
            if (scramble && n >= 1) begin
                bus_addr = ~a; bus_be_n = ~be; bus_wdata = ~d;
            end
            n++;
        end
        @(posedge clk); #1;
        if (gap > 0) begin
            bus_rd = 1'b0; bus_wr = 1'b0;
            repeat (gap) begin @(posedge clk); #1; end
        end
    endtask

    // Monitor: compares both instances against the scoreboard at each falling edge.
    always @(negedge clk) begin
        if (bus_rd || bus_wr) begin
            // R5: zero-count instance finishes at once; R7 conflict resolved to read
            chk("R5", "zero waitreq", 64'(z_waitreq), 64'(0));
            chk("R5", "zero rd_n", 64'(z_rd_n), 64'(!bus_rd));
            chk("R7", "zero wr_n", 64'(z_wr_n), 64'(!(bus_wr && !bus_rd)));
            chk("R5", "zero rdata", 64'(z_rdata), 64'(bus_rd ? pmodel(bus_addr) : '0));
            if (!rst) begin
                if (sb_q.size() == 0) begin
                    chk("R10", "request without item", 64'(1), 64'(0));
                end else begin
                    exp_t e;
                    bit   in_stb;
                    bit   is_last;
                    e = sb_q[0];
                    in_stb  = (cyc_k >= S) && (cyc_k <= S + W);
                    is_last = (cyc_k == e.len - 1);
                    chk("R3", "cs", 64'(per_cs), 64'(1));
                    chk("R3", "rd_n", 64'(per_rd_n), 64'(!(e.is_rd && in_stb)));
                    chk("R7", "wr_n", 64'(per_wr_n), 64'(!(e.is_wr && in_stb)));
                    chk("R6", "addr", 64'(per_addr), 64'(e.addr));
                    chk("R11", "be_n", 64'(per_be_n), 64'(e.be_n));
                    chk("R6", "wdata", 64'(per_wdata), 64'(e.wdata));
                    chk(e.is_wr ? "R4" : "R2", "waitreq", 64'(bus_waitreq), 64'(!is_last));
                    if (!bus_waitreq || cyc_k >= e.len) begin
                        chk("R8", "rdata", 64'(bus_rdata), 64'(e.is_rd ? pmodel(e.addr) : '0));
                        void'(sb_q.pop_front());
                        cyc_k = 0;
                    end else begin
                        chk("R8", "rdata mid", 64'(bus_rdata), 64'(0));
                        cyc_k++;
                    end
                end
            end
        end else begin
            // R1: quiet port
            chk("R1", "cs", 64'(per_cs), 64'(0));
            chk("R1", "rd_n", 64'(per_rd_n), 64'(1));
            chk("R1", "wr_n", 64'(per_wr_n), 64'(1));
            chk("R1", "waitreq", 64'(bus_waitreq), 64'(0));
            chk("R1", "rdata", 64'(bus_rdata), 64'(0));
            chk("R1", "zero cs", 64'(z_cs), 64'(0));
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) begin @(posedge clk); #1; end
        access(1, 0, 10'h015, 4'b0000, 32'h1111_2222, 0, 2);   // R2 plain read
        access(0, 1, 10'h2A3, 4'b0000, 32'hCAFE_0001, 0, 1);   // R4 plain write
        access(1, 0, 10'h101, 4'b1110, 32'h0, 0, 0);           // R10 back to back
        access(0, 1, 10'h102, 4'b0111, 32'hDEAD_BEEF, 0, 0);
        access(1, 0, 10'h103, 4'b1100, 32'h0, 0, 2);
        access(1, 1, 10'h3C4, 4'b0000, 32'h5555_AAAA, 0, 1);   // R7 conflict
        access(0, 1, 10'h0F0, 4'b1010, 32'h1234_5678, 1, 1);   // R6 scrambled write
        access(1, 0, 10'h377, 4'b0110, 32'h0, 1, 1);           // R6 scrambled read
        access(0, 1, 10'h001, 4'b0101, 32'hFFFF_0000, 0, 3);   // R11 lane pattern
        chk("R10", "scoreboard drained", 64'(sb_q.size()), 64'(0));
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule